// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is a hardware master for the two-wire station management bus used to reach Ethernet PHY registers. A host hands it a single request: read or write, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The block serializes that request into one complete frame on the management clock and data lines and then signals completion with a one-clock `done` pulse.

The management clock is made by dividing the system clock. Each half-period lasts `HALF_CYC` system clocks. The data line is split into an output, an output-enable and an input, so the pad and its tristate buffer stay outside the block. The input passes through a synchronizer, and its sample point sits at the end of the clock-high half so that the synchronizer delay is absorbed. `HALF_CYC` must exceed the synchronizer depth.

On reads, the block checks that a PHY actually pulls the line low during turnaround. When no PHY answers, it clocks the bus 32 more times with the line released. It then returns all-ones and raises `no_resp`.

Top module: `mdio_master`

## Requirements
- R1: Every frame begins with 32 management-clock cycles in which the master drives the data line high with the output-enable high.
- R2: After the preamble the master drives 0 then 1 (start), then the opcode: 1,0 for a read (`req_rd`=1) or 0,1 for a write (`req_rd`=0).
- R3: The PHY address follows as 5 bits, most significant bit first, and the register address follows it as 5 bits, also most significant bit first.
- R4: The master changes `mdio_out`/`mdio_oe` only while `mdc` is low, so both are stable across every rising edge. Each clock cycle lasts exactly `HALF_CYC` system clocks low and then `HALF_CYC` high.
- R5: A write continues with turnaround 1,0 and 16 data bits MSB first, all driven. A final 65th clock cycle follows with the line released.
- R6: A read releases the data line (`mdio_oe`=0) from the first turnaround cycle to the end of the frame.
- R7: When the line is low at the turnaround check, a read shifts in 16 bits MSB first, one per following clock cycle, sampled while `mdc` is high. The frame totals 65 rising edges, and `rdata` holds the value when `done` pulses, with `no_resp`=0.
- R8: When the line is high at the turnaround check, the master issues 32 further clock cycles without driving, for 79 rising edges in total. It then reports `rdata`=16'hFFFF and `no_resp`=1 with `done`.
- R9: A request is taken only while `busy` is low. Fields are captured at acceptance. Strobes while busy are ignored, and `done` pulses for exactly one system clock per frame.
- R10: Between frames and after reset, `mdc` is high, `mdio_oe` is low, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, taken when `busy` is low |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write value |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read result, valid with `done` |
| no_resp | output | 1 | Last read found no PHY |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output-enable |
| mdio_in | input | 1 | Data line input from the pad |

## Verification
The embedded properties are checked on every cycle. They cover the following: the output-enable and data never change across a rising management-clock edge, the clock idles high with the line released, `done` never lasts two clocks, a read never drives after turnaround, a busy strobe never disturbs the captured request, and a no-response completion always carries all-ones. Other behaviour shows only through the bench's scenarios, which play a PHY model against the bus. These scenarios cover the bit-level content of each frame: preamble, start, opcode, address order, write turnaround and data, read data assembly through the synchronizer, the 65 versus 79 edge frame lengths and exact half-period timing.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef logic [6:0] slot_t;

  // Frame slot map: one slot = one management clock cycle (low half, high half)
  localparam slot_t S_START    = 7'd32;  // preamble occupies slots 0..31
  localparam slot_t S_OP       = 7'd34;
  localparam slot_t S_PHY      = 7'd36;
  localparam slot_t S_REG      = 7'd41;
  localparam slot_t S_TA       = 7'd46;
  localparam slot_t S_RD_FIRST = 7'd47;  // first read data sample slot
  localparam slot_t S_RD_LAST  = 7'd62;
  localparam slot_t S_WR_DATA  = 7'd48;
  localparam slot_t S_END      = 7'd64;  // trailing cycle of a normal frame
  localparam slot_t S_ERR_END  = 7'd78;  // turnaround + 32 flush cycles

  typedef enum logic {OP_WRITE = 1'b0, OP_READ = 1'b1} mdio_op_e;

  typedef struct packed {
    mdio_op_e    op;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdata;
  } mdio_req_t;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic en,
  input  logic fin,
  output logic mdc,
  output logic half_end
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [CNT_W-1:0] cnt;

  assign half_end = en && (cnt == CNT_W'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      mdc <= 1'b1;
    end else if (go) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (en) begin
      if (half_end) begin
        cnt <= '0;
        if (!(fin && mdc)) mdc <= ~mdc;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
      mdc <= 1'b1;
    end
  end
endmodule

// File: rtl/mdio_sync.sv
module mdio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  mdio_req_t   req_in,
  input  logic        half_end,
  input  logic        mdc,
  input  logic        rx_bit,
  output logic        go,
  output logic        fin,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        no_resp,
  output logic        mdio_out,
  output logic        mdio_oe
);
  mdio_req_t   cur;
  slot_t       slot;
  logic        err;
  logic [15:0] rx;
  logic        is_rd;
  logic        last;
  logic        bit_end;
  logic        tx_oe, tx_bit;

  assign is_rd   = (cur.op == OP_READ);
  assign go      = req && !busy;
  assign last    = (slot == (err ? S_ERR_END : S_END));
  assign fin     = busy && last;
  assign bit_end = busy && half_end && mdc;

  // Line content for the current slot
  always_comb begin
    tx_oe  = 1'b0;
    tx_bit = 1'b0;
    if (slot < S_START) begin
      tx_oe = 1'b1; tx_bit = 1'b1;
    end else if (slot == S_START) begin
      tx_oe = 1'b1; tx_bit = 1'b0;
    end else if (slot == S_START + 7'd1) begin
      tx_oe = 1'b1; tx_bit = 1'b1;
    end else if (slot == S_OP) begin
      tx_oe = 1'b1; tx_bit = is_rd;
    end else if (slot == S_OP + 7'd1) begin
      tx_oe = 1'b1; tx_bit = !is_rd;
    end else if (slot < S_REG) begin
      tx_oe = 1'b1; tx_bit = cur.phy[3'd4 - 3'(slot - S_PHY)];
    end else if (slot < S_TA) begin
      tx_oe = 1'b1; tx_bit = cur.regad[3'd4 - 3'(slot - S_REG)];
    end else if (!is_rd) begin
      if (slot == S_TA) begin
        tx_oe = 1'b1; tx_bit = 1'b1;
      end else if (slot == S_TA + 7'd1) begin
        tx_oe = 1'b1; tx_bit = 1'b0;
      end else if (slot < S_END) begin
        tx_oe = 1'b1; tx_bit = cur.wdata[4'd15 - 4'(slot - S_WR_DATA)];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !busy) begin
      mdio_oe  <= 1'b0;
      mdio_out <= 1'b0;
    end else begin
      mdio_oe  <= tx_oe;
      mdio_out <= tx_oe & tx_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      slot    <= '0;
      cur     <= '0;
      err     <= 1'b0;
      rx      <= '0;
      rdata   <= '0;
      no_resp <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy <= 1'b1;
        slot <= '0;
        cur  <= req_in;
        err  <= 1'b0;
        rx   <= '0;
      end else if (bit_end) begin
        if (is_rd && slot == S_TA && rx_bit) err <= 1'b1;
        if (is_rd && !err && slot >= S_RD_FIRST && slot <= S_RD_LAST)
          rx <= {rx[14:0], rx_bit};
        if (last) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          no_resp <= is_rd && err;
          if (is_rd) rdata <= err ? 16'hFFFF : rx;
        end else begin
          slot <= slot + 7'd1;
        end
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R9
  AST_RD_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (busy && is_rd && slot > S_TA) |-> !mdio_oe);  // R6
  AST_BUSY_HOLDS_REQ: assert property (@(posedge clk) disable iff (rst)
    (busy && req) |=> $stable(cur));  // R9
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic        req_rd,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        no_resp,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  mdio_req_t req_pkt;
  logic go, fin, half_end, rx_bit;

  assign req_pkt = '{op: mdio_op_e'(req_rd), phy: req_phy, regad: req_reg, wdata: req_wdata};

  mdio_clkdiv #(.HALF_CYC(HALF_CYC)) u_div (
    .clk(clk), .rst(rst), .go(go), .en(busy), .fin(fin),
    .mdc(mdc), .half_end(half_end)
  );

  mdio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(mdio_in), .q(rx_bit)
  );

  mdio_seq u_seq (
    .clk(clk), .rst(rst), .req(req), .req_in(req_pkt),
    .half_end(half_end), .mdc(mdc), .rx_bit(rx_bit),
    .go(go), .fin(fin), .busy(busy), .done(done), .rdata(rdata),
    .no_resp(no_resp), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );

  AST_MDC_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> mdc);  // R10
  AST_OE_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);  // R10
  AST_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> ($stable(mdio_out) && $stable(mdio_oe)));  // R4
  AST_NORESP_ONES: assert property (@(posedge clk) disable iff (rst)
    (done && no_resp) |-> (rdata == 16'hFFFF));  // R8
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int HALF = 4;
  localparam logic [4:0] MODEL_PHY = 5'h0B;

  logic clk = 1'b0;
  logic rst, req, req_rd;
  logic [4:0] req_phy, req_reg;
  logic [15:0] req_wdata, rdata;
  logic busy, done, no_resp, mdc, mdio_out, mdio_oe, mdio_in;
  logic phy_drv, phy_val;

  always #4 clk = ~clk;

  assign mdio_in = mdio_oe ? mdio_out : (phy_drv ? phy_val : 1'b1);

  mdio_master #(.HALF_CYC(HALF), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .req(req), .req_rd(req_rd), .req_phy(req_phy),
    .req_reg(req_reg), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .no_resp(no_resp), .mdc(mdc), .mdio_out(mdio_out),
    .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  int nchk = 0, nfail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_data(input logic [4:0] p, input logic [4:0] r);
    return {r, 3'b101, p, 3'b010} ^ 16'h5A3C;
  endfunction

  // PHY model: records the line at each rising edge and answers reads
  int   ecount;
  logic lbit [1:100];
  logic loe  [1:100];
  logic hit;
  logic [15:0] resp;

  always @(posedge mdc) begin
    ecount = ecount + 1;
    if (ecount <= 100) begin
      lbit[ecount] = mdio_oe ? mdio_out : 1'b1;
      loe[ecount]  = mdio_oe;
    end
    if (ecount == 46) begin
      logic [4:0] p, r;
      for (int i = 0; i < 5; i++) begin
        p[4-i] = lbit[37+i];
        r[4-i] = lbit[42+i];
      end
      hit  = lbit[35] && !lbit[36] && (p == MODEL_PHY);
      resp = model_data(p, r);
    end
    if (hit && ecount == 47) begin phy_drv = 1'b1; phy_val = 1'b0; end
    if (hit && ecount >= 48 && ecount <= 63) phy_val = resp[63-ecount];
    if (ecount == 64) phy_drv = 1'b0;
  end

  // Timing and handshake monitor, sampled away from the active edge
  int cyc = 0, last_rise = -1, tbad = 0, chg_bad = 0, dcount = 0, dbad = 0;
  logic mdc_p = 1'b1, done_p = 1'b0;
  logic [1:0] line_p = 2'b00;

  always @(negedge clk) begin
    cyc++;
    if (mdc && !mdc_p) begin
      if (last_rise >= 0 && cyc - last_rise != 2*HALF) tbad++;
      last_rise = cyc;
    end
    if (!mdc && mdc_p && last_rise >= 0 && cyc - last_rise != HALF) tbad++;
    if (mdc && {mdio_out, mdio_oe} != line_p) chg_bad++;
    if (done && done_p) dbad++;
    if (done) dcount++;
    mdc_p = mdc; done_p = done; line_p = {mdio_out, mdio_oe};
  end

  task automatic run(input logic rd, input logic [4:0] p, input logic [4:0] r,
                     input logic [15:0] wd, input bit poke);
    int wait_n;
    logic ok, pre_ok;
    logic [4:0] gp, gr;
    logic [15:0] gd;
    bit is_hit;
    int exp_len;
    @(negedge clk);
    ecount = 0; hit = 1'b0; phy_drv = 1'b0; last_rise = -1;
    tbad = 0; chg_bad = 0; dcount = 0; dbad = 0;
    req = 1'b1; req_rd = rd; req_phy = p; req_reg = r; req_wdata = wd;
    @(negedge clk);
    req = 1'b0;
    req_rd = ~rd; req_phy = ~p; req_reg = ~r; req_wdata = ~wd;
    chk("R9 busy after accept", {31'd0, busy}, 32'd1);
    if (poke) begin
      repeat (37) @(negedge clk);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
    end
    wait_n = 0;
    while (!done && wait_n < 3000) begin @(negedge clk); wait_n++; end
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R9 watchdog actual=no_done expected=done");
      return;
    end
    is_hit  = rd && (p == MODEL_PHY);
    exp_len = (rd && !is_hit) ? 79 : 65;
    pre_ok = 1'b1;
    for (int i = 1; i <= 32; i++) if (!(lbit[i] && loe[i])) pre_ok = 1'b0;
    chk("R1 preamble", {31'd0, pre_ok}, 32'd1);
    chk("R2 start+op", {28'd0, lbit[33], lbit[34], lbit[35], lbit[36]},
        {28'd0, 2'b01, rd ? 2'b10 : 2'b01});
    for (int i = 0; i < 5; i++) begin gp[4-i] = lbit[37+i]; gr[4-i] = lbit[42+i]; end
    chk("R3 addresses", {22'd0, gp, gr}, {22'd0, p, r});
    chk("R4 timing/stability", tbad + chg_bad, 32'd0);
    chk("R8 frame length", ecount, exp_len);
    if (!rd) begin
      ok = lbit[47] && !lbit[48] && loe[47] && loe[48] && !loe[65];
      for (int i = 0; i < 16; i++) begin gd[15-i] = lbit[49+i]; if (!loe[49+i]) ok = 1'b0; end
      chk("R5 write ta/release", {31'd0, ok}, 32'd1);
      chk("R5 write data", {16'd0, gd}, {16'd0, wd});
    end else begin
      ok = 1'b1;
      for (int i = 47; i <= ecount; i++) if (loe[i]) ok = 1'b0;
      chk("R6 read released", {31'd0, ok}, 32'd1);
      if (is_hit) begin
        chk("R7 read data", {15'd0, no_resp, rdata}, {15'd0, 1'b0, model_data(p, r)});
      end else begin
        chk("R8 no response", {15'd0, no_resp, rdata}, {15'd0, 1'b1, 16'hFFFF});
      end
    end
    repeat (3) @(negedge clk);
    chk("R9 done single pulse", dcount + 100*dbad, 32'd1);
    chk("R10 idle lines", {29'd0, mdc, mdio_oe, busy}, {29'd0, 3'b100});
  endtask

  initial begin
    rst = 1'b1; req = 1'b0; req_rd = 1'b0; req_phy = '0; req_reg = '0; req_wdata = '0;
    phy_drv = 1'b0; phy_val = 1'b1; ecount = 0; hit = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 reset state", {27'd0, mdc, mdio_oe, busy, done, no_resp}, {27'd0, 5'b10000});
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 after reset", {29'd0, mdc, mdio_oe, busy}, {29'd0, 3'b100});
    // directed corners
    run(1'b1, MODEL_PHY, 5'h00, 16'h0000, 1'b0);
    run(1'b1, MODEL_PHY, 5'h1F, 16'h0000, 1'b0);
    run(1'b0, 5'h1F, 5'h00, 16'hFFFF, 1'b0);
    run(1'b0, 5'h00, 5'h1F, 16'h0000, 1'b0);
    run(1'b1, 5'h14, 5'h03, 16'h0000, 1'b0);  // absent PHY
    run(1'b1, MODEL_PHY, 5'h05, 16'h0000, 1'b1);  // R9 strobe while busy
    run(1'b0, 5'h0A, 5'h15, 16'h8001, 1'b1);
    void'($urandom(32'd20240611));
    for (int n = 0; n < 30; n++) begin
      logic [31:0] rv;
      rv = $urandom;
      run(rv[0], rv[1] ? MODEL_PHY : rv[6:2], rv[11:7], rv[31:16], rv[12] && rv[13]);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule